// File: doc/BRIEF.md
# Write Data Ordering Monitor

This block sits beside one write address channel and one write data channel of a memory-mapped bus that carries per-beat write IDs. It never drives the bus. Every cycle it samples the handshake, ID, burst length and last-beat signals and checks them against the write interleaving rules. These rules cover how many bursts may carry data at once, the order in which bursts may begin, the beat count of each burst, and whether a channel holds its VALID and payload until READY is seen.

Accepted addresses go into a table of outstanding transactions. Each entry is tagged with its arrival order. A data beat either continues a burst that has already started with the same ID, or it is the first beat of the oldest address whose data has not yet begun. A beat that arrives before its address waits in a small queue and is matched once the address has been stored.

Each broken rule sets its own sticky flag. In that cycle a one-cycle strobe also fires, together with a code that names the error. A count output shows how many bursts currently have data in progress.

Top module: `wr_interleave_chk`

## Requirements
- R1: A synchronous active-high reset clears all of the following: `err_flags`, `err_pulse`, `err_code`, `active_count`, the transaction table and the early-beat queue.
- R2: When `aw_valid` was high with `aw_ready` low on one edge, and at the next edge `aw_valid` is low or {`aw_id`,`aw_len`} has changed, the monitor sets `err_flags[0]` and reports code 1.
- R3: When `w_valid` was high with `w_ready` low on one edge, and at the next edge `w_valid` is low or {`w_id`,`w_last`} has changed, the monitor sets `err_flags[1]` and reports code 2.
- R4: A beat whose ID matches no burst in progress is a first beat. If its ID differs from the ID of the oldest accepted address whose data has not started, the monitor sets `err_flags[2]` and reports code 3.
- R5: If a first beat arrives while `DEPTH` bursts already have data in progress, the monitor sets `err_flags[3]` and reports code 4. With `DEPTH` = 1, no interleaving is allowed at all.
- R6: A burst of length field L must carry exactly L+1 beats, with `w_last` on the final beat only. A last beat that comes early, or a final beat without last, sets `err_flags[4]` and reports code 5.
- R7: An address handshake that arrives while all `TABLE_SIZE` entries are occupied is dropped, sets `err_flags[5]` and reports code 6.
- R8: A data beat whose address has not yet been stored is queued and resolved without error once the address arrives. A beat that arrives while the queue already holds `EARLY_DEPTH` beats sets `err_flags[6]` and reports code 7.
- R9: `active_count` equals the number of bursts that have received a first beat but not yet their final beat. It changes by at most one per cycle.
- R10: Flags stay set until reset. `err_pulse` is high only in the cycle an error is detected. In that cycle `err_code` holds the code of the lowest-numbered flag raised; otherwise `err_code` is 0.
- R11: Legal interleaving of up to `DEPTH` bursts, with first beats in address order, raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_id | input | ID_W | Address transaction ID |
| aw_len | input | LEN_W | Burst length minus one |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_id | input | ID_W | Data beat ID |
| w_last | input | 1 | Final beat marker |
| err_pulse | output | 1 | One-cycle strobe on any new violation |
| err_code | output | 3 | Code of the lowest-numbered violation in the strobe cycle |
| err_flags | output | 7 | Sticky violation flags, one bit per rule |
| active_count | output | $clog2(TABLE_SIZE+1) | Bursts with data in progress |

## Verification
A violation caused by live channel inputs shows up on the outputs right after the edge that samples those inputs. The bench therefore drives just after a falling edge and reads just after the next falling edge, one edge later. A beat that arrives ahead of its address is resolved two edges after the address handshake: the address is stored on one edge and the queued beat is consumed on the next. That test therefore inserts one idle cycle before it reads `active_count`. The hold-rule tests span two edges, one to open the pending handshake and one to break it, and they are read after the second edge.

// File: rtl/wic_pkg.sv
package wic_pkg;

    localparam int NUM_ERR = 7;

    localparam int E_AW_HOLD = 0;
    localparam int E_W_HOLD  = 1;
    localparam int E_ORDER   = 2;
    localparam int E_DEPTH   = 3;
    localparam int E_BEATS   = 4;
    localparam int E_TABLE   = 5;
    localparam int E_EARLY   = 6;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    // Code = flag index + 1; the lowest set flag wins, 0 means none.
    function automatic logic [2:0] lowest_code(err_vec_t v);
        logic [2:0] c;
        c = 3'd0;
        for (int i = NUM_ERR - 1; i >= 0; i--) begin
            if (v[i]) c = 3'(i + 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/wic_hold_mon.sv
module wic_hold_mon #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic         ready,
    input  logic [W-1:0] payload,
    output logic         err
);
    logic         pend_q;
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held_q <= '0;
        end else begin
            pend_q <= valid & ~ready;
            held_q <= payload;
        end
    end

    assign err = pend_q & (~valid | (payload != held_q));

endmodule

// File: rtl/wic_beat_fifo.sv
module wic_beat_fifo #(
    parameter int W     = 5,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (int'(cnt_q) == DEPTH);
    assign do_pop  = pop & ~empty;
    assign do_push = push & (~full | do_pop);
    assign dout    = mem[rd_q];

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_q] <= din;
                wr_q      <= nxt(wr_q);
            end
            if (do_pop) rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/wic_txn_table.sv
module wic_txn_table #(
    parameter int ID_W       = 4,
    parameter int LEN_W      = 4,
    parameter int TABLE_SIZE = 8,
    parameter int DEPTH      = 2,
    localparam int SEQ_W = $clog2(TABLE_SIZE) + 1,
    localparam int IDX_W = (TABLE_SIZE > 1) ? $clog2(TABLE_SIZE) : 1,
    localparam int CNT_W = $clog2(TABLE_SIZE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             aw_fire,
    input  logic [ID_W-1:0]  aw_id,
    input  logic [LEN_W-1:0] aw_len,
    input  logic             beat_valid,
    input  logic [ID_W-1:0]  beat_id,
    input  logic             beat_last,
    output logic             resolvable,
    output logic             err_order,
    output logic             err_depth,
    output logic             err_beats,
    output logic             err_full,
    output logic [CNT_W-1:0] active_count
);
    typedef struct packed {
        logic             valid;
        logic             started;
        logic [ID_W-1:0]  id;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] beats;
        logic [SEQ_W-1:0] seq;
    } entry_t;

    entry_t           tbl [TABLE_SIZE];
    logic [SEQ_W-1:0] alloc_seq_q, start_seq_q;
    logic [CNT_W-1:0] act_q;

    logic             full, hit, start_ok, consume, first, final_beat, retire;
    logic [IDX_W-1:0] free_idx, hit_idx, start_idx, sel_idx;
    entry_t           sel;

    always_comb begin
        full      = 1'b1;
        hit       = 1'b0;
        start_ok  = 1'b0;
        free_idx  = '0;
        hit_idx   = '0;
        start_idx = '0;
        for (int i = 0; i < TABLE_SIZE; i++) begin
            if (!tbl[i].valid && full) begin
                full     = 1'b0;
                free_idx = IDX_W'(i);
            end
            if (tbl[i].valid && tbl[i].started && tbl[i].id == beat_id && !hit) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (tbl[i].valid && !tbl[i].started && tbl[i].seq == start_seq_q) begin
                start_ok  = 1'b1;
                start_idx = IDX_W'(i);
            end
        end
    end

    assign resolvable = hit | start_ok;
    assign consume    = beat_valid & resolvable;
    assign first      = ~hit;
    assign sel_idx    = hit ? hit_idx : start_idx;
    assign sel        = tbl[sel_idx];
    assign final_beat = (sel.beats == sel.len);
    assign retire     = beat_last | final_beat;

    assign err_order  = consume & first & (sel.id != beat_id);
    assign err_depth  = consume & first & (int'(act_q) >= DEPTH);
    assign err_beats  = consume & (beat_last != final_beat);
    assign err_full   = aw_fire & full;

    assign active_count = act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_seq_q <= '0;
            start_seq_q <= '0;
            act_q       <= '0;
            for (int i = 0; i < TABLE_SIZE; i++) tbl[i] <= '0;
        end else begin
            if (consume) begin
                if (first) begin
                    tbl[sel_idx].started <= 1'b1;
                    start_seq_q          <= start_seq_q + 1'b1;
                end
                tbl[sel_idx].beats <= sel.beats + 1'b1;
                if (retire) tbl[sel_idx].valid <= 1'b0;
                if (first && !retire)      act_q <= act_q + 1'b1;
                else if (!first && retire) act_q <= act_q - 1'b1;
            end
            if (aw_fire && !full) begin
                tbl[free_idx] <= '{valid: 1'b1, started: 1'b0, id: aw_id,
                                   len: aw_len, beats: '0, seq: alloc_seq_q};
                alloc_seq_q   <= alloc_seq_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wr_interleave_chk.sv
module wr_interleave_chk
    import wic_pkg::*;
#(
    parameter int ID_W        = 4,
    parameter int LEN_W       = 4,
    parameter int TABLE_SIZE  = 8,
    parameter int DEPTH       = 2,
    parameter int EARLY_DEPTH = 4,
    localparam int CNT_W = $clog2(TABLE_SIZE + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             aw_valid,
    input  logic             aw_ready,
    input  logic [ID_W-1:0]  aw_id,
    input  logic [LEN_W-1:0] aw_len,
    input  logic             w_valid,
    input  logic             w_ready,
    input  logic [ID_W-1:0]  w_id,
    input  logic             w_last,
    output logic             err_pulse,
    output logic [2:0]       err_code,
    output logic [NUM_ERR-1:0] err_flags,
    output logic [CNT_W-1:0] active_count
);
    localparam int BEAT_W = ID_W + 1;

    logic              e_aw_hold, e_w_hold, e_order, e_depth, e_beats, e_full;
    logic              live, q_empty, q_full, q_push, q_pop, resolvable;
    logic [BEAT_W-1:0] q_head;
    logic              beat_valid, beat_last;
    logic [ID_W-1:0]   beat_id;
    err_vec_t          errs;

    wic_hold_mon #(.W(ID_W + LEN_W)) u_aw_hold (
        .clk(clk), .rst(rst), .valid(aw_valid), .ready(aw_ready),
        .payload({aw_id, aw_len}), .err(e_aw_hold)
    );

    wic_hold_mon #(.W(BEAT_W)) u_w_hold (
        .clk(clk), .rst(rst), .valid(w_valid), .ready(w_ready),
        .payload({w_id, w_last}), .err(e_w_hold)
    );

    // Beats are taken strictly in arrival order: the queue head first.
    assign live       = w_valid & w_ready;
    assign beat_valid = ~q_empty | live;
    assign {beat_id, beat_last} = q_empty ? {w_id, w_last} : q_head;
    assign q_pop      = ~q_empty & resolvable;
    assign q_push     = live & (~q_empty | ~resolvable);

    wic_beat_fifo #(.W(BEAT_W), .DEPTH(EARLY_DEPTH)) u_early (
        .clk(clk), .rst(rst), .push(q_push), .din({w_id, w_last}),
        .pop(q_pop), .dout(q_head), .empty(q_empty), .full(q_full)
    );

    wic_txn_table #(
        .ID_W(ID_W), .LEN_W(LEN_W), .TABLE_SIZE(TABLE_SIZE), .DEPTH(DEPTH)
    ) u_table (
        .clk(clk), .rst(rst),
        .aw_fire(aw_valid & aw_ready), .aw_id(aw_id), .aw_len(aw_len),
        .beat_valid(beat_valid), .beat_id(beat_id), .beat_last(beat_last),
        .resolvable(resolvable),
        .err_order(e_order), .err_depth(e_depth), .err_beats(e_beats),
        .err_full(e_full), .active_count(active_count)
    );

    always_comb begin
        errs            = '0;
        errs[E_AW_HOLD] = e_aw_hold;
        errs[E_W_HOLD]  = e_w_hold;
        errs[E_ORDER]   = e_order;
        errs[E_DEPTH]   = e_depth;
        errs[E_BEATS]   = e_beats;
        errs[E_TABLE]   = e_full;
        errs[E_EARLY]   = q_push & q_full & ~q_pop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flags <= '0;
            err_pulse <= 1'b0;
            err_code  <= 3'd0;
        end else begin
            err_flags <= err_flags | errs;
            err_pulse <= |errs;
            err_code  <= lowest_code(errs);
        end
    end

endmodule

// File: rtl/wr_interleave_chk_sva.sv
module wr_interleave_chk_sva #(
    parameter int TABLE_SIZE = 8,
    parameter int NFLAG      = 7,
    localparam int CNT_W = $clog2(TABLE_SIZE + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             aw_valid,
    input logic             aw_ready,
    input logic             w_valid,
    input logic             w_ready,
    input logic             err_pulse,
    input logic [2:0]       err_code,
    input logic [NFLAG-1:0] err_flags,
    input logic [CNT_W-1:0] active_count
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (err_flags == '0 && !err_pulse && active_count == '0));

    assert_aw_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (aw_valid && !aw_ready) ##1 !aw_valid |=> err_flags[0]);

    assert_w_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (w_valid && !w_ready) ##1 !w_valid |=> err_flags[1]);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        int'(active_count) <= TABLE_SIZE);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(active_count) <= int'($past(active_count)) + 1) &&
        (int'(active_count) + 1 >= int'($past(active_count))));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (($past(err_flags) & ~err_flags) == '0));

    assert_pulse_code_R10: assert property (@(posedge clk) disable iff (rst)
        err_pulse == (err_code != 3'd0));

    assert_pulse_flag_R10: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_flags[err_code - 3'd1]);
endmodule

bind wr_interleave_chk wr_interleave_chk_sva #(
    .TABLE_SIZE(TABLE_SIZE), .NFLAG(wic_pkg::NUM_ERR)
) u_sva (
    .clk(clk), .rst(rst), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .w_valid(w_valid), .w_ready(w_ready), .err_pulse(err_pulse),
    .err_code(err_code), .err_flags(err_flags), .active_count(active_count)
);

// File: tb/wr_interleave_chk_tb.sv
module wr_interleave_chk_tb;
    localparam int ID_W = 4, LEN_W = 4, TABLE_SIZE = 8, DEPTH = 2, EARLY_DEPTH = 4;
    localparam int CNT_W = $clog2(TABLE_SIZE + 1);

    logic clk = 1'b0, rst = 1'b1;
    logic aw_valid = 0, aw_ready = 1, w_valid = 0, w_ready = 1, w_last = 0;
    logic [ID_W-1:0]  aw_id = '0, w_id = '0;
    logic [LEN_W-1:0] aw_len = '0;
    logic             err_pulse;
    logic [2:0]       err_code;
    logic [6:0]       err_flags;
    logic [CNT_W-1:0] active_count;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    wr_interleave_chk #(
        .ID_W(ID_W), .LEN_W(LEN_W), .TABLE_SIZE(TABLE_SIZE),
        .DEPTH(DEPTH), .EARLY_DEPTH(EARLY_DEPTH)
    ) u_dut (.*);

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        aw_valid = 0; aw_ready = 1; w_valid = 0; w_ready = 1; w_last = 0;
    endtask

    task automatic do_reset();
        idle(); rst = 1; step(); step(); rst = 0; step();
    endtask

    task automatic send_aw(int id, int len);
        aw_valid = 1; aw_id = ID_W'(id); aw_len = LEN_W'(len);
        step(); aw_valid = 0;
    endtask

    task automatic send_w(int id, bit last);
        w_valid = 1; w_id = ID_W'(id); w_last = last;
        step(); w_valid = 0; w_last = 0;
    endtask

    task automatic expect_err(string req, int code);
        chk(req, "err_pulse", int'(err_pulse), 1);
        chk(req, "err_code", int'(err_code), code);
        chk(req, "flag bit", int'(err_flags[code-1]), 1);
    endtask

    task automatic t_legal_interleave();
        do_reset();
        send_aw(1, 1); send_aw(2, 1);
        send_w(1, 0); chk("R9", "count after A0", int'(active_count), 1);
        send_w(2, 0); chk("R9", "count after B0", int'(active_count), 2);
        send_w(1, 1); chk("R9", "count after A1", int'(active_count), 1);
        send_w(2, 1); chk("R9", "count after B1", int'(active_count), 0);
        chk("R11", "flags after legal interleave", int'(err_flags), 0);
    endtask

    task automatic t_order_and_sticky();
        do_reset();
        send_aw(1, 0); send_aw(2, 0);
        send_w(2, 1);
        expect_err("R4", 3);
        step(); step();
        chk("R10", "pulse gone", int'(err_pulse), 0);
        chk("R10", "code cleared", int'(err_code), 0);
        chk("R10", "flag kept", int'(err_flags), 7'b0000100);
        do_reset();
        chk("R1", "flags after reset", int'(err_flags), 0);
        chk("R1", "pulse after reset", int'(err_pulse), 0);
        chk("R1", "count after reset", int'(active_count), 0);
    endtask

    task automatic t_depth();
        do_reset();
        send_aw(1, 1); send_aw(2, 1); send_aw(3, 1);
        send_w(1, 0); send_w(2, 0);
        chk("R5", "no error at depth", int'(err_flags), 0);
        send_w(3, 0);
        expect_err("R5", 4);
    endtask

    task automatic t_beats();
        do_reset();
        send_aw(1, 2);
        send_w(1, 0); send_w(1, 1);
        expect_err("R6", 5);
        do_reset();
        send_aw(4, 0);
        send_w(4, 0);
        expect_err("R6", 5);
    endtask

    task automatic t_table_full();
        do_reset();
        for (int i = 0; i < TABLE_SIZE; i++) send_aw(i, 0);
        chk("R7", "no error while filling", int'(err_flags), 0);
        send_aw(9, 0);
        expect_err("R7", 6);
    endtask

    task automatic t_early();
        do_reset();
        send_w(5, 0);
        chk("R8", "early beat no error", int'(err_flags), 0);
        chk("R8", "early beat not counted", int'(active_count), 0);
        send_aw(5, 1);
        step();
        chk("R8", "early beat resolved", int'(active_count), 1);
        send_w(5, 1);
        chk("R8", "burst closed", int'(active_count), 0);
        chk("R8", "no flags", int'(err_flags), 0);
        do_reset();
        for (int i = 0; i < EARLY_DEPTH; i++) send_w(3, 0);
        chk("R8", "queue filled silently", int'(err_flags), 0);
        send_w(3, 0);
        expect_err("R8", 7);
    endtask

    task automatic t_hold();
        do_reset();
        aw_valid = 1; aw_ready = 0; aw_id = 4'd1; aw_len = 4'd0; step();
        aw_valid = 0; step();
        expect_err("R2", 1);
        do_reset();
        aw_valid = 1; aw_ready = 0; aw_id = 4'd1; aw_len = 4'd0; step();
        aw_len = 4'd3; step();
        expect_err("R2", 1);
        do_reset();
        w_valid = 1; w_ready = 0; w_id = 4'd2; w_last = 0; step();
        w_id = 4'd3; step();
        expect_err("R3", 2);
        do_reset();
        aw_valid = 1; aw_ready = 0; w_valid = 1; w_ready = 0; step();
        aw_valid = 0; w_valid = 0; step();
        chk("R10", "priority code", int'(err_code), 1);
        chk("R10", "both flags", int'(err_flags), 7'b0000011);
        do_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle();
        step(); step();
        rst = 0; step();
        chk("R1", "initial flags", int'(err_flags), 0);
        chk("R1", "initial count", int'(active_count), 0);
        t_legal_interleave();
        t_order_and_sticky();
        t_depth();
        t_beats();
        t_table_full();
        t_early();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule